// File: doc/BRIEF.md
# Signed Shift-by-Count Unit

This is a purely combinational arithmetic shifter. It shifts either one 16-bit word or a 32-bit value formed from a pair of words. The shift count is a small two's-complement field. A positive count shifts left and a negative count shifts right. The unit returns the shifted value together with four condition flags: negative (N), zero (Z), overflow (V) and carry (C).

A surrounding datapath reads the registers, places them on `reg_even` and `reg_odd`, and drives the count field and the mode select. It then writes `res_even` and `res_odd` back. In single-word mode only the even word is shifted, and the odd word passes through untouched. In pair mode the even word is the upper half of the 32-bit value and the odd word is the lower half.

Top module: `ash_unit`

## Requirements
- R1: `shift_amt` is a 6-bit two's-complement count. Values 1 to 31 shift left by that many places. Values 33 to 63 shift right by 64 minus the value, which is 31 down to 1. The value 32 shifts right by 32.
- R2: A count of 0 returns the operand unchanged, with C = 0 and V = 0.
- R3: A left shift fills with zeros from the right, and C is the last bit shifted out of the top of the operand.
- R4: On a left shift, V = 1 exactly when some bit shifted out differs from the sign bit (top bit) of the result. Otherwise V = 0.
- R5: In single-word mode, a left shift of 16 to 31 gives zero, and V = 1 exactly when the operand was nonzero. C equals operand bit 0 for a count of 16 and is 0 for counts above 16.
- R6: A right shift fills with copies of the operand sign bit. C is the last bit shifted out of bit 0, and V = 0.
- R7: A count of 32 yields every result bit equal to the operand sign, with C equal to that sign.
- R8: When `dbl_mode` = 1, the operand is {`reg_even`, `reg_odd`}. The upper result half goes to `res_even` and the lower half to `res_odd`. N is result bit 31, and Z is set when all 32 result bits are zero.
- R9: When `dbl_mode` = 0, the operand is `reg_even` and the result is on `res_even`. N is result bit 15, Z is set when the 16-bit result is zero, and `res_odd` equals `reg_odd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_even | input | 16 | Single-word operand, or upper half of the pair |
| reg_odd | input | 16 | Lower half of the pair; passed through in single mode |
| shift_amt | input | 6 | Signed shift count |
| dbl_mode | input | 1 | 1 selects the 32-bit pair, 0 the single word |
| res_even | output | 16 | Single-word result, or upper half of the pair result |
| res_odd | output | 16 | Lower half of the pair result, or `reg_odd` in single mode |
| flag_n | output | 1 | Result sign |
| flag_z | output | 1 | Result is zero |
| flag_v | output | 1 | Left-shift overflow |
| flag_c | output | 1 | Last bit shifted out |

## Verification
The bench sweeps all 64 count values in both modes. It uses fixed operands at the sign and zero boundaries, plus random operands.

- If the count decode were off by one at the 31/32/33 boundary, a large left shift would show up as a right shift, or the reverse.
- If the single-word left shift did not saturate to zero at counts of 16 and above, the wide-count vectors would show stray bits and a wrong C.
- An overflow test on only the top shifted-out bit would miss mixed patterns such as 0x5555 shifted by 2.
- A right shift that zero-fills would give wrong results for negative operands, most plainly at the count of 32.

// File: rtl/ash_pkg.sv
package ash_pkg;
  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2
  } sh_dir_e;
endpackage

// File: rtl/ash_count_dec.sv
module ash_count_dec
  import ash_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0] amt,
  output sh_dir_e       dir,
  output logic [CW-1:0] mag
);
  // Top bit of the field is the sign; negative values become a right-shift magnitude.
  always_comb begin
    if (amt == '0) begin
      dir = SH_NONE;
      mag = '0;
    end else if (!amt[CW-1]) begin
      dir = SH_LEFT;
      mag = amt;
    end else begin
      dir = SH_RIGHT;
      mag = CW'(0) - amt;
    end
  end
endmodule

// File: rtl/ash_left.sv
module ash_left #(
  parameter int W  = 16,
  parameter int CW = $clog2(4*W)
) (
  input  logic [4*W-1:0] ext,
  input  logic [CW-1:0]  mag,
  input  logic           dbl,
  output logic [2*W-1:0] res,
  output logic           c,
  output logic           v
);
  localparam int XW = 4*W;

  logic [XW-1:0]  prod;
  logic [XW-1:0]  low_ones;
  logic [1:0]     lane_c;
  logic [1:0]     lane_v;
  logic [2*W-1:0] lane_res [2];

  // One wide shift serves both widths; bits above the lane are the shifted-out ones.
  assign prod     = ext << mag;
  assign low_ones = ({{(XW-1){1'b0}}, 1'b1} << mag) - {{(XW-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int M = W << g;
    logic [XW-1:0]  out_mask;
    logic [2*W-1:0] keep;
    logic           rsign;
    assign out_mask    = low_ones << M;
    assign keep        = {(2*W){1'b1}} >> (2*W - M);
    assign rsign       = prod[M-1];
    assign lane_c[g]   = prod[M];
    assign lane_v[g]   = |((prod ^ {XW{rsign}}) & out_mask);
    assign lane_res[g] = prod[2*W-1:0] & keep;
  end

  assign res = dbl ? lane_res[1] : lane_res[0];
  assign c   = dbl ? lane_c[1]   : lane_c[0];
  assign v   = dbl ? lane_v[1]   : lane_v[0];
endmodule

// File: rtl/ash_right.sv
module ash_right #(
  parameter int W  = 16,
  parameter int CW = $clog2(4*W)
) (
  input  logic [2*W-1:0] ext2,
  input  logic [CW-1:0]  mag,
  output logic [2*W-1:0] res,
  output logic           c
);
  assign res = $signed(ext2) >>> mag;

  // Carry is the bit that sat at position mag-1 before the shift.
  always_comb begin
    c = 1'b0;
    for (int i = 0; i < 2*W; i++) begin
      if (CW'(i + 1) == mag) c = ext2[i];
    end
  end
endmodule

// File: rtl/ash_flags.sv
module ash_flags #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] res,
  input  logic           dbl,
  output logic           n,
  output logic           z
);
  assign n = dbl ? res[2*W-1] : res[W-1];
  assign z = dbl ? (res == '0) : (res[W-1:0] == '0);
endmodule

// File: rtl/ash_unit.sv
module ash_unit
  import ash_pkg::*;
#(
  parameter  int W  = 16,
  localparam int CW = $clog2(4*W)
) (
  input  logic [W-1:0]  reg_even,
  input  logic [W-1:0]  reg_odd,
  input  logic [CW-1:0] shift_amt,
  input  logic          dbl_mode,
  output logic [W-1:0]  res_even,
  output logic [W-1:0]  res_odd,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c
);
  sh_dir_e        dir;
  logic [CW-1:0]  mag;
  logic [4*W-1:0] ext;
  logic [2*W-1:0] l_res, r_res, res;
  logic           l_c, l_v, r_c;

  // Mode selection is folded into sign extension, so the shifters see one value.
  assign ext = dbl_mode ? {{(2*W){reg_even[W-1]}}, reg_even, reg_odd}
                        : {{(3*W){reg_even[W-1]}}, reg_even};

  ash_count_dec #(.CW(CW)) dec_i (.amt(shift_amt), .dir(dir), .mag(mag));

  ash_left #(.W(W), .CW(CW)) left_i (
    .ext(ext), .mag(mag), .dbl(dbl_mode), .res(l_res), .c(l_c), .v(l_v)
  );

  ash_right #(.W(W), .CW(CW)) right_i (
    .ext2(ext[2*W-1:0]), .mag(mag), .res(r_res), .c(r_c)
  );

  always_comb begin
    unique case (dir)
      SH_LEFT:  begin res = l_res; flag_c = l_c; flag_v = l_v; end
      SH_RIGHT: begin res = r_res; flag_c = r_c; flag_v = 1'b0; end
      default:  begin res = ext[2*W-1:0] & ({(2*W){1'b1}} >> (dbl_mode ? 0 : W));
                      flag_c = 1'b0; flag_v = 1'b0; end
    endcase
  end

  ash_flags #(.W(W)) flags_i (.res(res), .dbl(dbl_mode), .n(flag_n), .z(flag_z));

  assign res_even = dbl_mode ? res[2*W-1:W] : res[W-1:0];
  assign res_odd  = dbl_mode ? res[W-1:0]   : reg_odd;

  always_comb begin
    if (dir == SH_NONE) begin
      a_r2_zero_keeps: assert (res_even == reg_even && res_odd == reg_odd && !flag_c && !flag_v)
        else $error("R2 zero count altered operand or flags");
    end
    if (dir == SH_RIGHT) begin
      a_r6_right_no_v: assert (!flag_v) else $error("R6 right shift set V");
    end
    if (dir == SH_RIGHT && mag == CW'(2*W)) begin
      a_r7_sign_fill: assert (flag_c == reg_even[W-1] &&
                              res_even == {W{reg_even[W-1]}} &&
                              (!dbl_mode || res_odd == {W{reg_even[W-1]}}))
        else $error("R7 count 32 did not fill with sign");
    end
    if (!dbl_mode && dir == SH_LEFT && mag >= CW'(W)) begin
      a_r5_wide_left_zero: assert (res_even == '0 && flag_v == (reg_even != '0))
        else $error("R5 wide left shift result or V wrong");
    end
    a_r8_zero_flag: assert (flag_z == (dbl_mode ? ({res_even, res_odd} == '0) : (res_even == '0)))
      else $error("R8 R9 Z flag disagrees with result");
  end
endmodule

// File: tb/ash_unit_tb.sv
module ash_unit_tb_top;
  logic        clk;
  logic [15:0] reg_even, reg_odd;
  logic [5:0]  shift_amt;
  logic        dbl_mode;
  logic [15:0] res_even, res_odd;
  logic        flag_n, flag_z, flag_v, flag_c;

  int n_checks = 0;
  int n_fail   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  ash_unit dut_i (
    .reg_even(reg_even), .reg_odd(reg_odd), .shift_amt(shift_amt), .dbl_mode(dbl_mode),
    .res_even(res_even), .res_odd(res_odd),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  // Step-by-step model: {even, odd, n, z, v, c}
  function automatic logic [35:0] model(input logic dbl, input logic [15:0] e,
                                        input logic [15:0] o, input logic [5:0] amt);
    int m = dbl ? 32 : 16;
    logic [31:0] x = dbl ? {e, o} : {16'h0, e};
    logic sgn = x[m-1];
    logic c = 1'b0, v = 1'b0, all1 = 1'b1, all0 = 1'b1, b;
    if (amt != 0 && amt < 32) begin
      for (int s = 0; s < int'(amt); s++) begin
        b = x[m-1];
        c = b; all1 &= b; all0 &= ~b;
        x = x << 1;
        if (!dbl) x[31:16] = 16'h0;
      end
      v = x[m-1] ? ~all1 : ~all0;
    end else if (amt >= 32) begin
      for (int s = 0; s < 64 - int'(amt); s++) begin
        c = x[0];
        x = x >> 1;
        x[m-1] = sgn;
      end
    end
    model = {dbl ? x[31:16] : x[15:0], dbl ? x[15:0] : o, x[m-1],
             dbl ? (x == 0) : (x[15:0] == 0), v, c};
  endfunction

  function automatic string req_of(input logic dbl, input logic [5:0] amt);
    string r;
    if (amt == 0)                 r = "R2";
    else if (amt == 32)           r = "R7";
    else if (amt > 32)            r = "R6";
    else if (!dbl && amt >= 16)   r = "R5";
    else                          r = "R3+R4";
    return {r, " R1 ", dbl ? "R8" : "R9"};
  endfunction

  task automatic run_vec(input logic dbl, input logic [15:0] e, input logic [15:0] o,
                         input logic [5:0] amt);
    logic [35:0] exp_v, got_v;
    @(negedge clk);
    dbl_mode = dbl; reg_even = e; reg_odd = o; shift_amt = amt;
    @(posedge clk); #2;
    exp_v = model(dbl, e, o, amt);
    got_v = {res_even, res_odd, flag_n, flag_z, flag_v, flag_c};
    n_checks++;
    if (got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s mode=%0d e=%h o=%h cnt=%0d actual=%h expected=%h",
               req_of(dbl, amt), dbl, e, o, amt, got_v, exp_v);
    end
  endtask

  logic [15:0] pat [8];

  initial begin
    logic [15:0] e, o;
    void'($urandom(32'd1357));
    pat[0] = 16'h0000; pat[1] = 16'h0001; pat[2] = 16'h7FFF; pat[3] = 16'h8000;
    pat[4] = 16'hFFFF; pat[5] = 16'h5555; pat[6] = 16'hAAAA; pat[7] = 16'h4000;
    dbl_mode = 1'b0; reg_even = '0; reg_odd = '0; shift_amt = '0;
    // Idle state: all-zero inputs give zero result with Z set (R2)
    @(posedge clk); #2;
    n_checks++;
    if ({res_even, res_odd, flag_n, flag_z, flag_v, flag_c} !== {32'h0, 4'b0100}) begin
      n_fail++;
      $display("FAIL R2 idle actual=%h expected=%h",
               {res_even, res_odd, flag_n, flag_z, flag_v, flag_c}, {32'h0, 4'b0100});
    end
    for (int md = 0; md < 2; md++) begin
      for (int k = 0; k < 24; k++) begin
        if (k < 8) begin e = pat[k]; o = pat[7-k]; end
        else if (k < 12) begin e = pat[k-8]; o = pat[k-4]; end
        else begin e = 16'($urandom); o = 16'($urandom); end
        for (int a = 0; a < 64; a++) run_vec(md[0], e, o, 6'(a));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule